// File: doc/BRIEF.md
# Radix Tree Address Translation Walker

This block turns a 64-bit effective address into a physical address. It walks a multi-level radix tree that is held in memory. A request carries the address, a process ID, a load/store flag and a privilege flag. A process-table base register is presented alongside the request. The walker first reads the process-table entry, which names the root directory and gives its index width. It then descends one level per memory read. Each directory entry gives the width of the next index and the base of the next table.

Reads are 8 bytes wide and travel over a simple request/response port, with one read outstanding at a time. Table words arrive in big-endian byte order and are byte-reversed before any field is decoded. A walk ends in one of two ways:

- a one-cycle done pulse that carries the physical address, or
- a one-cycle fault pulse that carries a 3-bit cause.

Top module: `rdx_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `fault` and `mem_req_valid` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. From that edge until the cycle of the `done` or `fault` pulse, `req_ready` stays low and `req_valid` is ignored. In the pulse cycle `req_ready` is high again. Each pulse lasts one cycle, and `done` and `fault` are never high together. `mem_req_valid` is a one-cycle pulse, and the next read is not issued until `mem_rsp_valid` answers the previous one.
- R3: The first read of a walk goes to `{ptab_base[63:12],12'h000} | {pid, ea[63], 3'b000}`, with the PID left-aligned above bit 4. Bit 3 therefore picks the second doubleword of the 16-byte slot for addresses whose bit 63 is set.
- R4: Each read word is byte-reversed before decoding: `mem_rsp_data[7:0]` becomes bits 63:56 of the entry. Field positions below refer to the reversed entry.
- R5: The process-table entry gives the root size in bits 4:0. A root size of zero ends the walk with fault code 1.
- R6: The running shift starts at `{1'b0, ptab_base[4:0]}`. Every table size (bits 4:0, zero-extended to 6 bits) must lie in 5..16 and must not exceed the running shift. Otherwise the walk ends with fault code 2.
- R7: On each descent the size is subtracted from the shift. The next read address is `{entry[55:8],8'h00} | (((ea >> (12+shift)) & (2^w - 1)) << 3)`, where `shift` is the reduced value and `w` is `size[3:0]` (0 meaning 16).
- R8: At the directory and leaf levels, an entry with bit 63 (valid) clear ends the walk with fault code 3.
- R9: An entry with bit 62 (leaf) set ends the walk. Let `M = 2^(12+shift) - 1`. The physical address is `({8'h00, entry[55:0]} & ~M) | (ea & M)`.
- R10: At a leaf, a store needs bit 1 (write allowed) and an unprivileged request needs bit 3 (user access). A failed check gives fault code 4 and no address. A privileged request ignores bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_ea | input | 64 | Effective address to translate |
| req_pid | input | PID_W | Process ID |
| req_store | input | 1 | 1 for store, 0 for load |
| req_priv | input | 1 | 1 for a privileged request |
| ptab_base | input | 64 | Process-table base (bits 63:12) and initial shift (bits 4:0) |
| mem_req_valid | output | 1 | Read request pulse |
| mem_req_addr | output | 64 | Byte address of the 8-byte read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data, big-endian byte order |
| done | output | 1 | Translation finished, address valid |
| fault | output | 1 | Walk aborted |
| fault_code | output | 3 | 1 no root, 2 bad tree, 3 invalid entry, 4 permission |
| res_pa | output | 64 | Physical address |

## Verification
The main walk is tried with trees of several shapes:

- A two-level tree of 9-bit indices checks index extraction at both shift values.
- A root of width 5 leading straight to a huge leaf shows that leaf bits under the large offset mask are discarded.
- A root of width 16 checks the mask-width wrap where the low four bits are zero.
- An address with bit 63 set shows the second doubleword of the process-table slot being used.

Fault trees separately cover these cases:

- a zero root size;
- sizes just outside the 5..16 window;
- a size larger than the remaining shift;
- a cleared valid bit;
- each permission combination.

Together these tell the causes apart by their codes. A request held high during a busy walk must leave the first result and the read count unchanged.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int WORD_W = 64;
  localparam int NXT_LSB = 8;
  localparam int NXT_MSB = 55;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NOROOT  = 3'd1,
    FLT_BADTREE = 3'd2,
    FLT_INVALID = 3'd3,
    FLT_PERM    = 3'd4
  } flt_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;

  typedef struct packed {
    logic              valid;
    logic              leaf;
    logic              wr_ok;
    logic              usr_ok;
    logic [4:0]        sz;
    logic [WORD_W-1:0] nxt_base;
    logic [WORD_W-1:0] word;
  } ent_t;
endpackage

// File: rtl/rdx_entry_dec.sv
module rdx_entry_dec
  import rdx_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  output ent_t              ent
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] le;

  // byte reversal: big-endian memory word to little-endian bit numbering
  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_swap
      assign le[8*b +: 8] = raw[8*(NBYTES-1-b) +: 8];
    end
  endgenerate

  always_comb begin
    ent.word     = le;
    ent.valid    = le[63];
    ent.leaf     = le[62];
    ent.wr_ok    = le[1];
    ent.usr_ok   = le[3];
    ent.sz       = le[4:0];
    ent.nxt_base = '0;
    ent.nxt_base[NXT_MSB:NXT_LSB] = le[NXT_MSB:NXT_LSB];
  end
endmodule

// File: rtl/rdx_addr_gen.sv
module rdx_addr_gen
  import rdx_pkg::*;
#(
  parameter int PAGE_SH = 12,
  parameter int ENT_SH  = 3
) (
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] ea,
  input  logic [5:0]        shift,
  input  logic [3:0]        msz,
  output logic [WORD_W-1:0] addr
);
  logic [6:0]        sh_tot;
  logic [4:0]        width;
  logic [WORD_W-1:0] idx_mask;
  logic [WORD_W-1:0] idx;

  always_comb begin
    sh_tot   = 7'(PAGE_SH) + {1'b0, shift};
    width    = (msz == 4'd0) ? 5'd16 : {1'b0, msz};
    idx_mask = (64'd1 << width) - 64'd1;
    idx      = (ea >> sh_tot) & idx_mask;
    addr     = base | (idx << ENT_SH);
  end
endmodule

// File: rtl/rdx_leaf_chk.sv
module rdx_leaf_chk
  import rdx_pkg::*;
#(
  parameter int PAGE_SH = 12
) (
  input  ent_t              ent,
  input  logic [WORD_W-1:0] ea,
  input  logic [5:0]        shift,
  input  logic              is_store,
  input  logic              is_priv,
  output logic [WORD_W-1:0] pa,
  output logic              perm_bad
);
  logic [6:0]        off_bits;
  logic [WORD_W-1:0] off_mask;
  logic [WORD_W-1:0] frame;

  always_comb begin
    off_bits = 7'(PAGE_SH) + {1'b0, shift};
    off_mask = (64'd1 << off_bits) - 64'd1;
    frame    = {8'h00, ent.word[NXT_MSB:0]};
    pa       = (frame & ~off_mask) | (ea & off_mask);
    perm_bad = (is_store && !ent.wr_ok) || (!is_priv && !ent.usr_ok);
  end
endmodule

// File: rtl/rdx_walker.sv
module rdx_walker
  import rdx_pkg::*;
#(
  parameter int PID_W   = 16,
  parameter int PAGE_SH = 12,
  parameter int MIN_SZ  = 5,
  parameter int MAX_SZ  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_ea,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              req_store,
  input  logic              req_priv,
  input  logic [63:0]       ptab_base,
  output logic              mem_req_valid,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [63:0]       res_pa
);
  localparam int PT_ALIGN = 12;
  localparam int PAD_W    = WORD_W - PID_W - 4;

  st_e              st;
  logic             at_root;
  logic [5:0]       shift_q;
  logic [63:0]      ea_q;
  logic             store_q;
  logic             priv_q;

  ent_t             ent;
  logic [5:0]       sz6;
  logic [5:0]       nshift;
  logic             sz_bad;
  logic [63:0]      nxt_addr;
  logic [63:0]      leaf_pa;
  logic             perm_bad;
  logic [63:0]      prte_addr;
  logic             accept;

  rdx_entry_dec u_dec (
    .raw (mem_rsp_data),
    .ent (ent)
  );

  always_comb begin
    sz6    = {1'b0, ent.sz};
    nshift = shift_q - sz6;
    sz_bad = (sz6 < 6'(MIN_SZ)) || (sz6 > 6'(MAX_SZ)) || (sz6 > shift_q);
    accept = req_valid && req_ready;
    prte_addr = {ptab_base[63:PT_ALIGN], {PT_ALIGN{1'b0}}}
              | {{PAD_W{1'b0}}, req_pid, req_ea[63], 3'b000};
  end

  rdx_addr_gen #(.PAGE_SH(PAGE_SH), .ENT_SH(3)) u_agen (
    .base  (ent.nxt_base),
    .ea    (ea_q),
    .shift (nshift),
    .msz   (sz6[3:0]),
    .addr  (nxt_addr)
  );

  rdx_leaf_chk #(.PAGE_SH(PAGE_SH)) u_leaf (
    .ent      (ent),
    .ea       (ea_q),
    .shift    (shift_q),
    .is_store (store_q),
    .is_priv  (priv_q),
    .pa       (leaf_pa),
    .perm_bad (perm_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      at_root       <= 1'b0;
      shift_q       <= '0;
      ea_q          <= '0;
      store_q       <= 1'b0;
      priv_q        <= 1'b0;
      req_ready     <= 1'b1;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      done          <= 1'b0;
      fault         <= 1'b0;
      fault_code    <= FLT_NONE;
      res_pa        <= '0;
    end else begin
      done          <= 1'b0;
      fault         <= 1'b0;
      mem_req_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st            <= ST_WAIT;
            at_root       <= 1'b1;
            shift_q       <= {1'b0, ptab_base[4:0]};
            ea_q          <= req_ea;
            store_q       <= req_store;
            priv_q        <= req_priv;
            req_ready     <= 1'b0;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= prte_addr;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (at_root && ent.sz == 5'd0) begin
              fault <= 1'b1; fault_code <= FLT_NOROOT;
              st <= ST_IDLE; req_ready <= 1'b1;
            end else if (!at_root && !ent.valid) begin
              fault <= 1'b1; fault_code <= FLT_INVALID;
              st <= ST_IDLE; req_ready <= 1'b1;
            end else if (!at_root && ent.leaf) begin
              st <= ST_IDLE; req_ready <= 1'b1;
              if (perm_bad) begin
                fault <= 1'b1; fault_code <= FLT_PERM;
              end else begin
                done <= 1'b1; fault_code <= FLT_NONE; res_pa <= leaf_pa;
              end
            end else if (sz_bad) begin
              fault <= 1'b1; fault_code <= FLT_BADTREE;
              st <= ST_IDLE; req_ready <= 1'b1;
            end else begin
              shift_q       <= nshift;
              at_root       <= 1'b0;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= nxt_addr;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  busy_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && mem_req_valid));
  // R2
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |=> !(done || fault));
  // R2
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R9
  page_off_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_pa[PAGE_SH-1:0] == ea_q[PAGE_SH-1:0]));
endmodule

// File: tb/rdx_walker_test.sv
`timescale 1ns/1ps
module rdx_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ea = '0;
  logic [15:0] req_pid = '0;
  logic        req_store = 1'b0;
  logic        req_priv = 1'b1;
  logic [63:0] ptab_base = 64'h10012;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [2:0]  fault_code;
  logic [63:0] res_pa;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rdx_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_pid(req_pid), .req_store(req_store), .req_priv(req_priv),
    .ptab_base(ptab_base), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_code(fault_code), .res_pa(res_pa)
  );

  // memory model, table words held in little-endian numbering
  logic [63:0] mem [logic [63:0]];
  logic [63:0] pend_addr = '0;
  int          lat_cnt = 0;
  int          rd_n = 0;
  logic [63:0] rd_log [16];

  function automatic logic [63:0] to_be(input logic [63:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = w[8*(7-i) +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= to_be(mem.exists(pend_addr) ? mem[pend_addr] : 64'h0);
      end
    end
    if (mem_req_valid) begin
      pend_addr        <= mem_req_addr;
      lat_cnt          <= 2;
      rd_log[rd_n%16]  <= mem_req_addr;
      rd_n             <= rd_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected values built from the requirement formulas
  function automatic logic [63:0] lvl_addr(input logic [63:0] base, input logic [63:0] ea,
                                           input int shift, input int size);
    logic [63:0] m;
    m = (size == 16) ? 64'hFFFF : ((64'd1 << size) - 1);
    return base | (((ea >> (12 + shift)) & m) << 3);
  endfunction
  function automatic logic [63:0] mk_dir(input logic [63:0] base, input int size);
    return 64'h8000_0000_0000_0000 | base | 64'(size);
  endfunction
  function automatic logic [63:0] mk_leaf(input logic [63:0] rpn, input bit w, input bit u);
    return 64'hC000_0000_0000_0000 | rpn | (64'(w) << 1) | (64'(u) << 3);
  endfunction

  logic [63:0] g_pa;
  logic [2:0]  g_code;
  logic        g_done, g_fault, g_rdy_bad, g_rdy_end, g_pulse_bad, g_tmo;
  int          g_rd0;

  task automatic run_walk(input logic [63:0] ea, input logic [15:0] pid,
                          input bit st, input bit pv, input bit hold);
    int n;
    @(negedge clk);
    g_rd0 = rd_n;
    req_valid = 1'b1; req_ea = ea; req_pid = pid; req_store = st; req_priv = pv;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    else begin req_ea = ~ea; req_pid = ~pid; end
    g_rdy_bad = 1'b0; n = 0;
    while (!(done || fault) && n < 60) begin
      if (req_ready) g_rdy_bad = 1'b1;
      @(negedge clk); n++;
    end
    g_tmo = (n >= 60);
    g_pa = res_pa; g_code = fault_code; g_done = done; g_fault = fault;
    g_rdy_end = req_ready;
    req_valid = 1'b0;
    @(negedge clk);
    g_pulse_bad = done || fault;
  endtask

  task automatic std_tree(input logic [63:0] ea, input logic [63:0] leaf);
    mem.delete();
    ptab_base = 64'h10012;
    mem[64'h10030] = 64'h20000 | 64'd9;
    mem[lvl_addr(64'h20000, ea, 9, 9)] = mk_dir(64'h30000, 9);
    mem[lvl_addr(64'h30000, ea, 0, 9)] = leaf;
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    check(done === 1'b0 && fault === 1'b0, "R1 pulses", {62'd0, done, fault}, 64'd0);
    check(mem_req_valid === 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_basic;
    logic [63:0] ea = 64'h1234_5678;
    std_tree(ea, mk_leaf(64'hABCDE000, 1, 1));
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_done && !g_fault && !g_tmo, "R9 done", {62'd0, g_done, g_fault}, 64'd2);
    check(g_pa == 64'hABCDE678, "R9 two-level pa", g_pa, 64'hABCDE678);
    check(rd_log[g_rd0%16] == 64'h10030, "R3 prte addr", rd_log[g_rd0%16], 64'h10030);
    check(rd_log[(g_rd0+1)%16] == 64'h20488, "R7 level1 addr", rd_log[(g_rd0+1)%16], 64'h20488);
    check(rd_log[(g_rd0+2)%16] == 64'h30A28, "R4 R7 level2 addr", rd_log[(g_rd0+2)%16], 64'h30A28);
    check(!g_rdy_bad && g_rdy_end, "R2 ready low while busy", {62'd0, g_rdy_bad, g_rdy_end}, 64'd1);
    check(!g_pulse_bad, "R2 single pulse", 64'(g_pulse_bad), 64'd0);
    check(rd_n - g_rd0 == 3, "R2 read count", 64'(rd_n - g_rd0), 64'd3);
  endtask

  task automatic t_busy;
    logic [63:0] ea = 64'h1234_5678;
    std_tree(ea, mk_leaf(64'hABCDE000, 1, 1));
    run_walk(ea, 16'd3, 0, 1, 1);
    check(g_done && g_pa == 64'hABCDE678, "R2 request ignored while busy", g_pa, 64'hABCDE678);
    check(rd_n - g_rd0 == 3, "R2 no extra reads", 64'(rd_n - g_rd0), 64'd3);
  endtask

  task automatic t_perm;
    logic [63:0] ea = 64'h1234_5678;
    std_tree(ea, mk_leaf(64'hABCDE000, 0, 1));
    run_walk(ea, 16'd3, 1, 1, 0);
    check(g_fault && g_code == 3'd4, "R10 store without write", 64'(g_code), 64'd4);
    std_tree(ea, mk_leaf(64'hABCDE000, 1, 0));
    run_walk(ea, 16'd3, 0, 0, 0);
    check(g_fault && g_code == 3'd4, "R10 user without access", 64'(g_code), 64'd4);
    run_walk(ea, 16'd3, 1, 1, 0);
    check(g_done && g_pa == 64'hABCDE678, "R10 privileged ignores user bit", g_pa, 64'hABCDE678);
    std_tree(ea, mk_leaf(64'hABCDE000, 1, 1));
    run_walk(ea, 16'd3, 1, 0, 0);
    check(g_done && g_pa == 64'hABCDE678, "R10 user store allowed", g_pa, 64'hABCDE678);
  endtask

  task automatic t_huge;
    logic [63:0] ea = 64'h1234_5678;
    mem.delete();
    ptab_base = 64'h10012;
    mem[64'h10030] = 64'h20000 | 64'd9;
    mem[lvl_addr(64'h20000, ea, 9, 9)] = mk_leaf(64'h4000_0000, 1, 1);
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_done && g_pa == 64'h4014_5678, "R9 huge leaf 21-bit offset", g_pa, 64'h4014_5678);
    // root width 5, leaf at shift 13, low rpn bits dropped
    mem.delete();
    mem[64'h10030] = 64'h20000 | 64'd5;
    mem[lvl_addr(64'h20000, ea, 13, 5)] = mk_leaf(64'h0601_2000, 1, 1);
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_done && g_pa == 64'h0634_5678, "R9 R6 size 5 leaf mask", g_pa, 64'h0634_5678);
    // root width 16 (mask field 0 means 16)
    mem.delete();
    ptab_base = 64'h10019;
    mem[64'h10030] = 64'h20000 | 64'd16;
    mem[lvl_addr(64'h20000, ea, 9, 16)] = mk_dir(64'h30000, 9);
    mem[lvl_addr(64'h30000, ea, 0, 9)] = mk_leaf(64'h7000, 1, 1);
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_done && g_pa == 64'h7678, "R7 size 16 index", g_pa, 64'h7678);
  endtask

  task automatic t_faults;
    logic [63:0] ea = 64'h1234_5678;
    mem.delete();
    ptab_base = 64'h10012;
    mem[64'h10030] = 64'h20000;
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_fault && g_code == 3'd1, "R5 zero root size", 64'(g_code), 64'd1);
    mem[64'h10030] = 64'h20000 | 64'd4;
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_fault && g_code == 3'd2, "R6 size 4", 64'(g_code), 64'd2);
    mem[64'h10030] = 64'h20000 | 64'd17;
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_fault && g_code == 3'd2, "R6 size 17", 64'(g_code), 64'd2);
    ptab_base = 64'h10008;
    mem[64'h10030] = 64'h20000 | 64'd9;
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_fault && g_code == 3'd2, "R6 size over shift", 64'(g_code), 64'd2);
    ptab_base = 64'h10012;
    mem[lvl_addr(64'h20000, ea, 9, 9)] = mk_dir(64'h30000, 10);
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_fault && g_code == 3'd2, "R6 level size over shift", 64'(g_code), 64'd2);
    mem[lvl_addr(64'h20000, ea, 9, 9)] = 64'h0000_0000_0003_0009;
    run_walk(ea, 16'd3, 0, 1, 0);
    check(g_fault && g_code == 3'd3, "R8 invalid entry", 64'(g_code), 64'd3);
    check(!g_pulse_bad && g_rdy_end, "R2 fault pulse", {62'd0, g_pulse_bad, g_rdy_end}, 64'd1);
  endtask

  task automatic t_quadrant;
    logic [63:0] ea = 64'h8000_0000_1234_5678;
    mem.delete();
    ptab_base = 64'h10012;
    mem[64'h10030] = 64'h0;
    mem[64'h10038] = 64'h20000 | 64'd9;
    mem[lvl_addr(64'h20000, ea, 9, 9)] = mk_dir(64'h30000, 9);
    mem[lvl_addr(64'h30000, ea, 0, 9)] = mk_leaf(64'h5000, 1, 1);
    run_walk(ea, 16'd3, 0, 1, 0);
    check(rd_log[g_rd0%16] == 64'h10038, "R3 upper quadrant slot", rd_log[g_rd0%16], 64'h10038);
    check(g_done && g_pa == 64'h5678, "R3 upper quadrant pa", g_pa, 64'h5678);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_perm();
    t_huge();
    t_faults();
    t_quadrant();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule